// File: doc/BRIEF.md
# Staged CSR Field Bank

This block holds a small set of control/status fields packed into one bus word. Each field has its own width, bit position, reset value and software access policy. Software updates it through a word-wide write port. Hardware has three ports of its own: a write port, a set port and a clear port. Hardware writes ignore the software policy.

No update is visible straight away. Every operation changes only a staged copy of each field. A commit strobe publishes the staged copy into the committed copy, and an abort strobe rolls the staged copy back to the committed one. Two read views show the committed state: the hardware view returns every field's true value, and the software view hides fields that software may not read back. A third output shows the software view of the staged copy, so a caller can see what its last operation produced before it decides to commit or abort.

The field layout and the access policies are parameters. The logic for each field is generated from them, so one bank can hold any mix of policies.

Top module: `csr_stage_bank`

## Requirements
- R1: With the default parameters the bank has five fields. They are, as (lsb, width, policy, reset): (0, 8, read-write, 0x5A), (8, 4, read-only, 0x3), (12, 4, write-only, 0x9), (16, 8, write-one-to-clear, 0xF0) and (24, 6, write-one-to-clear reading as zero, 0x15). Bits 30 and 31 belong to no field and always read 0. While reset is high, and in the first cycle after it, the committed and staged copies both hold the reset values. This gives hardware view 0x15F0935A, software view 0x00F0035A and staged view 0x00F0035A.
- R2: Writes, sets and clears change only the staged copy. Both committed views keep their value until a commit.
- R3: A software write to a read-write or write-only field replaces the staged value with bits [lsb +: width] of the written word. Bits outside every field have no effect.
- R4: A software write to a read-only field leaves it unchanged. A hardware write to the same field replaces its value.
- R5: A software write to either write-one-to-clear field clears each staged bit whose data bit is 1 and keeps the others. A hardware write to such a field replaces its value.
- R6: In the software view and the staged view, the write-only field and the clear-on-one field that reads as zero always read 0. The hardware view shows their committed value.
- R7: The hardware set port ORs bits into the staged value, and the hardware clear port removes bits from it. Both work on every field, whatever its policy.
- R8: When several operations arrive in one cycle, they apply in this order: hardware write, then software write, then set, then clear.
- R9: A commit copies the staged copy into the committed copy. The staged copy includes any operations from the same cycle, and the result is visible on the next cycle.
- R10: An abort reloads the staged copy from the committed copy and discards any operations from the same cycle. If commit and abort are high together, the abort wins and the committed copy is kept.
- R11: The staged view shows the software-visible staged value from the cycle after each operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | DW | Software write word |
| hw_wr_en | input | 1 | Hardware write strobe |
| hw_wr_data | input | DW | Hardware write word |
| hw_set_en | input | 1 | Hardware set strobe |
| hw_set_data | input | DW | Bits to set |
| hw_clr_en | input | 1 | Hardware clear strobe |
| hw_clr_data | input | DW | Bits to clear |
| commit_i | input | 1 | Publish the staged copy |
| abort_i | input | 1 | Discard the staged copy |
| hw_rd_data | output | DW | Committed word, hardware view |
| sw_rd_data | output | DW | Committed word, software view |
| staged_sw_data | output | DW | Staged word, software view |

## Verification
The bench uses the default parameters: five fields, one for each access policy, at unequal widths, with a two-bit gap above the last field. This lets one test word exercise every policy at once and also shows whether stray bits in the gap are ignored. The default reset values have a mix of ones and zeros in every field, so a clear-on-one write, a set and a clear each produce a value that differs from both the old value and the written data. The reset value of the write-only field is non-zero, so the bench can see that the software view hides it while the hardware view shows it.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    typedef enum logic [2:0] {
        ACC_RW    = 3'd0,
        ACC_RO    = 3'd1,
        ACC_WO    = 3'd2,
        ACC_RW1C  = 3'd3,
        ACC_R0W1C = 3'd4
    } acc_e;

    // the software view of the field is always zero
    function automatic logic hides_from_sw(acc_e a);
        return (a == ACC_WO) || (a == ACC_R0W1C);
    endfunction

    // a software write clears the bits where the data holds a one
    function automatic logic sw_clears(acc_e a);
        return (a == ACC_RW1C) || (a == ACC_R0W1C);
    endfunction

    // a software write has no effect on the field
    function automatic logic sw_blocked(acc_e a);
        return a == ACC_RO;
    endfunction

    typedef struct packed {
        logic wr_hw;
        logic wr_sw;
        logic set;
        logic clr;
    } op_strobes_t;

endpackage

// File: rtl/csr_field_update.sv
module csr_field_update
    import csr_bank_pkg::*;
#(
    parameter int   W   = 8,
    parameter acc_e ACC = ACC_RW
) (
    input  logic        clk,
    input  logic        rst,
    input  op_strobes_t stb,
    input  logic [W-1:0] nxt_q,
    input  logic [W-1:0] hw_val,
    input  logic [W-1:0] sw_val,
    input  logic [W-1:0] set_val,
    input  logic [W-1:0] clr_val,
    output logic [W-1:0] nxt_d
);

    logic [W-1:0] after_hw;
    logic [W-1:0] after_sw;
    logic [W-1:0] after_set;

    // fixed order: hardware write, software write, set, clear
    always_comb begin
        after_hw = stb.wr_hw ? hw_val : nxt_q;
        after_sw = after_hw;
        if (stb.wr_sw) begin
            if (sw_blocked(ACC)) begin
                after_sw = after_hw;
            end else if (sw_clears(ACC)) begin
                after_sw = after_hw & ~sw_val;
            end else begin
                after_sw = sw_val;
            end
        end
        after_set = stb.set ? (after_sw | set_val) : after_sw;
        nxt_d     = stb.clr ? (after_set & ~clr_val) : after_set;
    end

    generate
        if (ACC == ACC_RO) begin : g_ro_chk
            // R4
            ro_sw_ignored_chk: assert property (@(posedge clk) disable iff (rst)
                (stb.wr_sw && !stb.wr_hw && !stb.set && !stb.clr) |-> (nxt_d == nxt_q));
        end
        if (ACC == ACC_RW1C || ACC == ACC_R0W1C) begin : g_w1c_chk
            // R5
            w1c_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
                (stb.wr_sw && !stb.wr_hw && !stb.set) |-> ((nxt_d & ~nxt_q) == '0));
        end
    endgenerate

    // R7
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (stb.set && !stb.clr) |-> ((nxt_d & set_val) == set_val));

    // R7
    clr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        stb.clr |-> ((nxt_d & clr_val) == '0));

endmodule

// File: rtl/csr_field_regs.sv
module csr_field_regs #(
    parameter int         W     = 8,
    parameter logic [W-1:0] RESET = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit_i,
    input  logic         abort_i,
    input  logic [W-1:0] nxt_d,
    output logic [W-1:0] cur_q,
    output logic [W-1:0] nxt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= RESET;
            nxt_q <= RESET;
        end else if (abort_i) begin
            nxt_q <= cur_q;
        end else if (commit_i) begin
            cur_q <= nxt_d;
            nxt_q <= nxt_d;
        end else begin
            nxt_q <= nxt_d;
        end
    end

    // R10
    abort_restore_chk: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (nxt_q == $past(cur_q)) && (cur_q == $past(cur_q)));

    // R9
    commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !abort_i) |=> (cur_q == nxt_q));

    // R2
    cur_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit_i || abort_i) |=> (cur_q == $past(cur_q)));

endmodule

// File: rtl/csr_stage_bank.sv
module csr_stage_bank
    import csr_bank_pkg::*;
#(
    parameter int   NF           = 5,
    parameter int   DW           = 32,
    parameter int   F_LSB   [NF] = '{0, 8, 12, 16, 24},
    parameter int   F_WIDTH [NF] = '{8, 4, 4, 8, 6},
    parameter int   F_RESET [NF] = '{'h5A, 'h3, 'h9, 'hF0, 'h15},
    parameter acc_e F_ACC   [NF] = '{ACC_RW, ACC_RO, ACC_WO, ACC_RW1C, ACC_R0W1C}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_wr_en,
    input  logic [DW-1:0] sw_wr_data,
    input  logic          hw_wr_en,
    input  logic [DW-1:0] hw_wr_data,
    input  logic          hw_set_en,
    input  logic [DW-1:0] hw_set_data,
    input  logic          hw_clr_en,
    input  logic [DW-1:0] hw_clr_data,
    input  logic          commit_i,
    input  logic          abort_i,
    output logic [DW-1:0] hw_rd_data,
    output logic [DW-1:0] sw_rd_data,
    output logic [DW-1:0] staged_sw_data
);

    function automatic logic [DW-1:0] cover_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < NF; i++) begin
            for (int b = 0; b < F_WIDTH[i]; b++) begin
                m[F_LSB[i] + b] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [DW-1:0] COVER = cover_mask();

    op_strobes_t stb;
    assign stb = '{wr_hw: hw_wr_en, wr_sw: sw_wr_en, set: hw_set_en, clr: hw_clr_en};

    logic [DW-1:0] hw_part  [NF];
    logic [DW-1:0] sw_part  [NF];
    logic [DW-1:0] stg_part [NF];

    generate
        for (genvar g = 0; g < NF; g++) begin : g_field
            localparam int W = F_WIDTH[g];
            localparam int L = F_LSB[g];

            logic [W-1:0] cur_q;
            logic [W-1:0] nxt_q;
            logic [W-1:0] nxt_d;

            csr_field_update #(
                .W   (W),
                .ACC (F_ACC[g])
            ) u_upd (
                .clk     (clk),
                .rst     (rst),
                .stb     (stb),
                .nxt_q   (nxt_q),
                .hw_val  (hw_wr_data[L +: W]),
                .sw_val  (sw_wr_data[L +: W]),
                .set_val (hw_set_data[L +: W]),
                .clr_val (hw_clr_data[L +: W]),
                .nxt_d   (nxt_d)
            );

            csr_field_regs #(
                .W     (W),
                .RESET (W'(F_RESET[g]))
            ) u_regs (
                .clk      (clk),
                .rst      (rst),
                .commit_i (commit_i),
                .abort_i  (abort_i),
                .nxt_d    (nxt_d),
                .cur_q    (cur_q),
                .nxt_q    (nxt_q)
            );

            assign hw_part[g] = DW'(cur_q) << L;
            if (hides_from_sw(F_ACC[g])) begin : g_hidden
                assign sw_part[g]  = '0;
                assign stg_part[g] = '0;
            end else begin : g_visible
                assign sw_part[g]  = DW'(cur_q) << L;
                assign stg_part[g] = DW'(nxt_q) << L;
            end
        end
    endgenerate

    always_comb begin
        hw_rd_data     = '0;
        sw_rd_data     = '0;
        staged_sw_data = '0;
        for (int i = 0; i < NF; i++) begin
            hw_rd_data     = hw_rd_data     | hw_part[i];
            sw_rd_data     = sw_rd_data     | sw_part[i];
            staged_sw_data = staged_sw_data | stg_part[i];
        end
    end

    logic unused_gap_bits;
    assign unused_gap_bits = ^{sw_wr_data & ~COVER, hw_wr_data & ~COVER,
                               hw_set_data & ~COVER, hw_clr_data & ~COVER};

    // R6
    sw_view_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_rd_data & ~hw_rd_data) == '0);

    // R1
    gap_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((hw_rd_data | staged_sw_data) & ~COVER) == '0);

endmodule

// File: tb/sim_csr_stage_bank.sv
module sim_csr_stage_bank;

    localparam int NF = 5;
    localparam int DW = 32;
    localparam int M_LSB [NF] = '{0, 8, 12, 16, 24};
    localparam int M_WID [NF] = '{8, 4, 4, 8, 6};
    localparam int M_RST [NF] = '{'h5A, 'h3, 'h9, 'hF0, 'h15};
    // 0 read-write, 1 read-only, 2 write-only, 3 w1c, 4 w1c reading zero
    localparam int M_POL [NF] = '{0, 1, 2, 3, 4};

    logic          clk = 1'b0;
    logic          rst;
    logic          sw_wr_en, hw_wr_en, hw_set_en, hw_clr_en, commit_i, abort_i;
    logic [DW-1:0] sw_wr_data, hw_wr_data, hw_set_data, hw_clr_data;
    logic [DW-1:0] hw_rd_data, sw_rd_data, staged_sw_data;

    always #4 clk = ~clk;

    csr_stage_bank u0 (
        .clk(clk), .rst(rst),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .hw_wr_en(hw_wr_en), .hw_wr_data(hw_wr_data),
        .hw_set_en(hw_set_en), .hw_set_data(hw_set_data),
        .hw_clr_en(hw_clr_en), .hw_clr_data(hw_clr_data),
        .commit_i(commit_i), .abort_i(abort_i),
        .hw_rd_data(hw_rd_data), .sw_rd_data(sw_rd_data),
        .staged_sw_data(staged_sw_data)
    );

    typedef struct {
        logic [DW-1:0] hw;
        logic [DW-1:0] sw;
        logic [DW-1:0] stg;
        string         tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic        done   = 1'b0;
    int unsigned m_cur [NF];
    int unsigned m_nxt [NF];

    function automatic int unsigned fmask(int w);
        return (32'h1 << w) - 1;
    endfunction

    function automatic int unsigned field_of(logic [DW-1:0] d, int i);
        return (d >> M_LSB[i]) & fmask(M_WID[i]);
    endfunction

    function automatic logic [DW-1:0] pack(int unsigned v [NF], logic sw_side);
        logic [DW-1:0] r;
        r = '0;
        for (int i = 0; i < NF; i++) begin
            if (!(sw_side && (M_POL[i] == 2 || M_POL[i] == 4)))
                r = r | (DW'(v[i]) << M_LSB[i]);
        end
        return r;
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.hw  = pack(m_cur, 1'b0);
        e.sw  = pack(m_cur, 1'b1);
        e.stg = pack(m_nxt, 1'b1);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic op(input logic hwe, input logic [DW-1:0] hwd,
                      input logic swe, input logic [DW-1:0] swd,
                      input logic se,  input logic [DW-1:0] sd,
                      input logic ce,  input logic [DW-1:0] cd,
                      input logic cm,  input logic ab, input string tag);
        int unsigned v;
        @(posedge clk);
        #2;
        hw_wr_en = hwe; hw_wr_data = hwd; sw_wr_en = swe; sw_wr_data = swd;
        hw_set_en = se; hw_set_data = sd; hw_clr_en = ce; hw_clr_data = cd;
        commit_i = cm;  abort_i = ab;
        for (int i = 0; i < NF; i++) begin
            v = m_nxt[i];
            if (hwe) v = field_of(hwd, i);
            if (swe) begin
                if (M_POL[i] == 1)                       v = v;
                else if (M_POL[i] == 3 || M_POL[i] == 4) v = v & ~field_of(swd, i);
                else                                     v = field_of(swd, i);
            end
            if (se) v = v | field_of(sd, i);
            if (ce) v = v & ~field_of(cd, i);
            if (ab) m_nxt[i] = m_cur[i];
            else if (cm) begin m_cur[i] = v; m_nxt[i] = v; end
            else m_nxt[i] = v;
        end
        push(tag);
    endtask

    task automatic idle(string tag);
        op(0, '0, 0, '0, 0, '0, 0, '0, 0, 0, tag);
    endtask

    // monitor: compare after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (hw_rd_data !== e.hw || sw_rd_data !== e.sw || staged_sw_data !== e.stg) begin
                    errors++;
                    $display("FAIL %s: hw=%h sw=%h stg=%h expected hw=%h sw=%h stg=%h",
                             e.tag, hw_rd_data, sw_rd_data, staged_sw_data, e.hw, e.sw, e.stg);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        sw_wr_en = 0; hw_wr_en = 0; hw_set_en = 0; hw_clr_en = 0; commit_i = 0; abort_i = 0;
        sw_wr_data = '0; hw_wr_data = '0; hw_set_data = '0; hw_clr_data = '0;
        for (int i = 0; i < NF; i++) begin m_cur[i] = M_RST[i]; m_nxt[i] = M_RST[i]; end
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        push("R1 reset state");

        // R3 R4 R5 R6 R2: software all-ones write, staged only
        op(0, '0, 1, 32'hFFFF_FFFF, 0, '0, 0, '0, 0, 0, "R3/R4/R5 sw all-ones staged");
        idle("R2 committed unchanged before commit");
        op(0, '0, 0, '0, 0, '0, 0, '0, 1, 0, "R9 commit sw write");
        idle("R6 views after commit");
        // R4 R5: hardware writes replace even read-only and w1c fields
        op(1, 32'hC7A5_6C3E, 0, '0, 0, '0, 0, '0, 1, 0, "R4/R5 hw write replaces, commit same cycle");
        op(0, '0, 1, 32'h0A0F_F0C3, 0, '0, 0, '0, 0, 0, "R5 partial w1c and R3 wo replace");
        op(0, '0, 0, '0, 0, '0, 0, '0, 1, 0, "R9 commit partial");
        // R7 set/clear on every policy
        op(0, '0, 0, '0, 1, 32'hC000_0F0F, 0, '0, 0, 0, "R7 set all policies, gap bits ignored");
        op(0, '0, 0, '0, 0, '0, 1, 32'h3F3C_3333, 0, 0, "R7 clear all policies");
        op(0, '0, 0, '0, 0, '0, 0, '0, 1, 0, "R9 commit set/clear");
        // R8 same-cycle ordering
        op(1, 32'h1234_5678, 1, 32'h00FF_00F0, 1, 32'h0102_0304, 1, 32'h0100_0104, 0, 0,
           "R8 hw then sw then set then clear");
        op(1, 32'h3F00_00AA, 0, '0, 1, 32'h0000_0001, 1, 32'h0000_0001, 1, 0,
           "R8 set then clear same bit, R9 commit");
        // R10 abort
        op(1, 32'h0000_0000, 0, '0, 0, '0, 0, '0, 0, 0, "R2 staged zeroes");
        op(0, '0, 0, '0, 0, '0, 0, '0, 0, 1, "R10 abort restores staged");
        op(1, 32'h2A55_5A5A, 0, '0, 0, '0, 0, '0, 1, 1, "R10 abort beats commit");
        op(0, '0, 1, 32'h0000_0011, 0, '0, 0, '0, 0, 1, "R10 abort drops same-cycle write");
        idle("R11 staged view after abort");

        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            r = $urandom;
            op(r[0], $urandom, r[1], $urandom, r[2], $urandom, r[3], $urandom,
               (r[7:4] == 0), (r[11:8] == 0), "R8/R9/R10/R11 random mix");
        end
        repeat (3) idle("R2 idle hold");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule